// File: doc/BRIEF.md
# Per-Line Variable-Size Bus Inversion Codec

This block prepares one compressed cache line for a byte-wide data bus. The line arrives in a 64-byte slot together with the length of its compressed payload and a requested inversion-code size of 0, 1, 2 or 3 bytes. The payload is cut into words whose size follows from the code size. Each word goes out either unchanged or with every bit flipped, whichever toggles fewer bus wires against the byte last driven. One flag bit per word records the choice. The flags are packed into the code, and the code is written into the slot's free space directly after the payload.

The requested code size is cut down so that payload plus code always fit in the slot. The size actually used comes back as a 2-bit field so the receiver knows how many code bytes follow the payload. A combinational decoder in the same top module takes an encoded slot, the payload length and the size field, and restores the original payload. Lines pass through a valid/ready handshake. The encoder handles one word per clock, and the last bus byte is remembered from one line to the next.

Top module: `dbi_line_codec`

## Requirements
- R1: After reset the block accepts input (`in_ready` = 1), presents no output (`out_valid` = 0), and the remembered last bus byte is 0x00.
- R2: A payload length above 64 is treated as 64 and reported as such on `out_len`. The size used is the smaller of the requested size and 64 minus that length, and it is reported on `out_size` (0 = no code, 1/2/3 = that many code bytes).
- R3: With size 1, each word is 8 bytes (8 words). With size 2, each word is 4 bytes (16 words). With size 3, each word is 3 bytes (22 words, the last one 1 byte). Word k's flag is bit k of `out_code`, so it sits in code byte k/8 at bit k%8. Bits for words that do not exist are 0.
- R4: A word is inverted when its first payload byte differs from the remembered bus byte in more than 4 of 8 bits. A difference of exactly 4 bits or fewer sends the word unchanged. An inverted word has all of its payload bytes XORed with 0xFF.
- R5: With size 0 the payload is sent unchanged and `out_code` is 0. A word that starts at or past the payload length has flag 0.
- R6: In `out_line`, bytes below the length hold the encoded payload. Code byte j sits at byte offset length + j for j below the size. Every later byte is 0x00.
- R7: After each line the remembered bus byte becomes the last encoded payload byte of that line. A line of length 0 leaves it unchanged.
- R8: Once a line is accepted, `in_ready` stays low until the result has been taken. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R9: Given an encoded slot, its length and its size field, the decoder outputs the original payload in bytes below the length and 0x00 above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input line offered |
| in_ready | output | 1 | Encoder idle and accepting |
| in_line | input | 512 | Slot contents, byte 0 in bits 7:0 |
| in_len | input | 7 | Compressed payload length in bytes |
| in_size | input | 2 | Requested code size in bytes |
| out_valid | output | 1 | Encoded line available |
| out_ready | input | 1 | Consumer takes the encoded line |
| out_line | output | 512 | Encoded payload followed by code bytes |
| out_code | output | 24 | Per-word inversion flags |
| out_len | output | 7 | Clamped payload length |
| out_size | output | 2 | Code size actually used |
| dec_line | input | 512 | Encoded slot to decode |
| dec_len | input | 7 | Payload length of the encoded slot |
| dec_size | input | 2 | Size field of the encoded slot |
| dec_data | output | 512 | Restored payload, zero beyond length |

## Verification
The encoder is driven with all-zero and all-ones payloads, which separate "invert always" from "invert never" faults. Alternating 0x55/0xAA bytes flip the decision on every word. Bytes exactly 4 bits away from the remembered bus byte expose a wrong tie rule. Lengths of 0, 1, 26, 62, 63, 64 and above 64, combined with every requested size, exercise the size clamp, the word count per size and where the code bytes land. Random lines sent back to back with varying output stalls check that the remembered bus byte carries across lines and that every encoding decodes back to its payload.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int LINE_BYTES = 64;
    localparam int LEN_W      = $clog2(LINE_BYTES + 1);
    localparam int BIDX_W     = $clog2(LINE_BYTES);
    localparam int SIZE_MAX   = 3;
    localparam int CODE_BITS  = 8 * SIZE_MAX;
    localparam int WIDX_W     = $clog2(CODE_BITS);
    localparam int HALF_BITS  = 4;

    // bytes per word for each code size, and resulting word counts
    localparam int WB1 = (LINE_BYTES + 7) / 8;
    localparam int WB2 = (LINE_BYTES + 15) / 16;
    localparam int WB3 = (LINE_BYTES + 23) / 24;
    localparam int NW1 = (LINE_BYTES + WB1 - 1) / WB1;
    localparam int NW2 = (LINE_BYTES + WB2 - 1) / WB2;
    localparam int NW3 = (LINE_BYTES + WB3 - 1) / WB3;

    typedef logic [1:0]                  dbi_size_t;
    typedef logic [LEN_W-1:0]            len_t;
    typedef logic [LINE_BYTES-1:0][7:0]  line_t;
    typedef logic [CODE_BITS-1:0]        code_t;
    typedef logic [WIDX_W-1:0]           widx_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_state_t;

    typedef struct packed {
        line_t     data;
        len_t      len;
        dbi_size_t size;
    } line_req_t;

    function automatic len_t word_bytes(input dbi_size_t s);
        case (s)
            2'd1:    return len_t'(WB1);
            2'd2:    return len_t'(WB2);
            2'd3:    return len_t'(WB3);
            default: return len_t'(LINE_BYTES);
        endcase
    endfunction

    function automatic widx_t word_count(input dbi_size_t s);
        case (s)
            2'd1:    return widx_t'(NW1);
            2'd2:    return widx_t'(NW2);
            2'd3:    return widx_t'(NW3);
            default: return widx_t'(0);
        endcase
    endfunction

    function automatic widx_t byte_word(input int idx, input dbi_size_t s);
        case (s)
            2'd1:    return widx_t'(idx / WB1);
            2'd2:    return widx_t'(idx / WB2);
            2'd3:    return widx_t'(idx / WB3);
            default: return widx_t'(0);
        endcase
    endfunction

    function automatic logic [3:0] popcount8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int b = 0; b < 8; b++) n = n + 4'(v[b]);
        return n;
    endfunction

    function automatic len_t clamp_len(input len_t l);
        return (l > len_t'(LINE_BYTES)) ? len_t'(LINE_BYTES) : l;
    endfunction

    function automatic dbi_size_t fit_size(input len_t l_c, input dbi_size_t req);
        len_t room;
        room = len_t'(LINE_BYTES) - l_c;
        return (len_t'(req) > room) ? room[1:0] : req;
    endfunction

endpackage

// File: rtl/dbi_word_engine.sv
module dbi_word_engine
    import dbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    output logic      in_ready,
    input  line_req_t in_req,
    output logic      out_valid,
    input  logic      out_ready,
    output line_t     line_o,
    output len_t      len_o,
    output dbi_size_t size_o,
    output code_t     code_o
);

    eng_state_t state_q;
    line_t      line_q;
    len_t       len_q;
    dbi_size_t  size_q;
    widx_t      widx_q;
    code_t      code_q;
    logic [7:0] hist_q;

    len_t          wb;
    widx_t         wcnt;
    len_t          start_b;
    logic [LEN_W:0] next_start;
    len_t          last_b;
    logic [7:0]    first_b;
    logic          inv;
    logic          fin;
    line_t         line_step;
    len_t          in_last;

    always_comb begin
        wb         = word_bytes(size_q);
        wcnt       = word_count(size_q);
        start_b    = len_t'(widx_q) * wb;
        next_start = {1'b0, start_b} + {1'b0, wb};
        last_b     = (next_start > {1'b0, len_q}) ? (len_q - len_t'(1))
                                                  : (start_b + wb - len_t'(1));
        first_b    = line_q[start_b[BIDX_W-1:0]];
        inv        = popcount8(first_b ^ hist_q) > 4'(HALF_BITS);
        fin        = (widx_q == wcnt - widx_t'(1)) || (next_start >= {1'b0, len_q});
        in_last    = in_req.len - len_t'(1);
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (inv && (byte_word(i, size_q) == widx_q) && (len_t'(i) < len_q))
                line_step[i] = ~line_q[i];
            else
                line_step[i] = line_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            len_q   <= '0;
            size_q  <= '0;
            widx_q  <= '0;
            code_q  <= '0;
            hist_q  <= 8'h00;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        line_q <= in_req.data;
                        len_q  <= in_req.len;
                        size_q <= in_req.size;
                        widx_q <= '0;
                        code_q <= '0;
                        if (in_req.len == '0) begin
                            state_q <= ST_DONE;
                        end else if (in_req.size == 2'd0) begin
                            hist_q  <= in_req.data[in_last[BIDX_W-1:0]];
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    line_q         <= line_step;
                    code_q[widx_q] <= inv;
                    hist_q         <= line_q[last_b[BIDX_W-1:0]] ^ {8{inv}};
                    widx_q         <= widx_q + widx_t'(1);
                    if (fin) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DONE);
    assign line_o    = line_q;
    assign len_o     = len_q;
    assign size_o    = size_q;
    assign code_o    = code_q;

endmodule

// File: rtl/dbi_code_pack.sv
module dbi_code_pack
    import dbi_pkg::*;
(
    input  line_t     payload,
    input  len_t      len,
    input  dbi_size_t size,
    input  code_t     code,
    output line_t     slot
);

    logic [SIZE_MAX-1:0][7:0] code_bytes;
    len_t rel;

    always_comb begin
        code_bytes = code;
        rel        = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (len_t'(i) < len) begin
                slot[i] = payload[i];
            end else begin
                rel = len_t'(i) - len;
                if (rel < len_t'(size))
                    slot[i] = code_bytes[rel[1:0]];
                else
                    slot[i] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/dbi_line_decoder.sv
module dbi_line_decoder
    import dbi_pkg::*;
(
    input  line_t     slot,
    input  len_t      len,
    input  dbi_size_t size,
    output line_t     payload
);

    len_t                     len_c;
    logic [SIZE_MAX-1:0][7:0] code_bytes;
    code_t                    flags;
    logic [LEN_W:0]           pos;
    logic                     inv;

    always_comb begin
        len_c = clamp_len(len);
        pos   = '0;
        for (int j = 0; j < SIZE_MAX; j++) begin
            pos = {1'b0, len_c} + (LEN_W+1)'(j);
            if ((pos < (LEN_W+1)'(LINE_BYTES)) && (j < int'(size)))
                code_bytes[j] = slot[pos[BIDX_W-1:0]];
            else
                code_bytes[j] = 8'h00;
        end
        flags = code_bytes;
        inv   = 1'b0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            inv = (size != 2'd0) && flags[byte_word(i, size)];
            if (len_t'(i) < len_c)
                payload[i] = slot[i] ^ {8{inv}};
            else
                payload[i] = 8'h00;
        end
    end

endmodule

// File: rtl/dbi_line_codec.sv
module dbi_line_codec
    import dbi_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [LINE_BYTES*8-1:0]   in_line,
    input  logic [LEN_W-1:0]          in_len,
    input  logic [1:0]                in_size,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [LINE_BYTES*8-1:0]   out_line,
    output logic [CODE_BITS-1:0]      out_code,
    output logic [LEN_W-1:0]          out_len,
    output logic [1:0]                out_size,
    input  logic [LINE_BYTES*8-1:0]   dec_line,
    input  logic [LEN_W-1:0]          dec_len,
    input  logic [1:0]                dec_size,
    output logic [LINE_BYTES*8-1:0]   dec_data
);

    line_req_t req;
    line_t     raw;
    line_t     eng_line;
    len_t      eng_len;
    dbi_size_t eng_size;
    code_t     eng_code;
    line_t     slot;
    line_t     dec_out;

    always_comb begin
        raw      = in_line;
        req.len  = clamp_len(in_len);
        req.size = fit_size(req.len, in_size);
        for (int i = 0; i < LINE_BYTES; i++)
            req.data[i] = (len_t'(i) < req.len) ? raw[i] : 8'h00;
    end

    dbi_word_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_req    (req),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .line_o    (eng_line),
        .len_o     (eng_len),
        .size_o    (eng_size),
        .code_o    (eng_code)
    );

    dbi_code_pack u_pack (
        .payload (eng_line),
        .len     (eng_len),
        .size    (eng_size),
        .code    (eng_code),
        .slot    (slot)
    );

    dbi_line_decoder u_dec (
        .slot    (line_t'(dec_line)),
        .len     (dec_len),
        .size    (dec_size),
        .payload (dec_out)
    );

    assign out_line = slot;
    assign out_code = eng_code;
    assign out_len  = eng_len;
    assign out_size = eng_size;
    assign dec_data = dec_out;

endmodule

// File: rtl/dbi_line_codec_chk.sv
module dbi_line_codec_chk
    import dbi_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LINE_BYTES*8-1:0] out_line,
    input logic [CODE_BITS-1:0]    out_code,
    input logic [LEN_W-1:0]        out_len,
    input logic [1:0]              out_size
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (in_ready && !out_valid)); // R1

    AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len <= LEN_W'(LINE_BYTES))); // R2

    AST_CODE_FITS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (({1'b0, out_len} + (LEN_W+1)'(out_size)) <= (LEN_W+1)'(LINE_BYTES))); // R2

    AST_SIZE1_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_size == 2'd1) |-> (out_code[CODE_BITS-1:8] == '0)); // R3

    AST_NO_CODE_RAW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_size == 2'd0) |-> (out_code == '0)); // R5

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R8

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line) && $stable(out_code)
                                       && $stable(out_size) && $stable(out_len))); // R8

endmodule

bind dbi_line_codec dbi_line_codec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_line  (out_line),
    .out_code  (out_code),
    .out_len   (out_len),
    .out_size  (out_size)
);

// File: tb/dbi_line_codec_tb.sv
module dbi_line_codec_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_line = '0;
    logic [6:0]   in_len = '0;
    logic [1:0]   in_size = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_line;
    logic [23:0]  out_code;
    logic [6:0]   out_len;
    logic [1:0]   out_size;
    logic [511:0] dec_line = '0;
    logic [6:0]   dec_len = '0;
    logic [1:0]   dec_size = '0;
    logic [511:0] dec_data;

    always #10 clk = ~clk;

    dbi_line_codec dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_len(in_len), .in_size(in_size),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_line(out_line), .out_code(out_code),
        .out_len(out_len), .out_size(out_size),
        .dec_line(dec_line), .dec_len(dec_len), .dec_size(dec_size),
        .dec_data(dec_data)
    );

    typedef struct {
        logic [511:0] slot;
        logic [23:0]  code;
        logic [6:0]   len;
        logic [1:0]   size;
        logic [511:0] payload;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_seen   = 0;
    logic [7:0] model_hist = 8'h00;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [511:0] act,
                         input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected result computed from the requirements
    task automatic build_exp(input logic [511:0] data, input int len_in, input int req,
                             input string tag, output exp_t e);
        int L, S, wb;
        logic inv;
        L = (len_in > 64) ? 64 : len_in;
        S = (req > 64 - L) ? 64 - L : req;
        e.slot = '0; e.code = '0; e.payload = '0; e.tag = tag;
        e.len = 7'(L); e.size = 2'(S);
        for (int b = 0; b < L; b++) e.payload[b*8 +: 8] = data[b*8 +: 8];
        if (S == 0) begin
            e.slot = e.payload;
            if (L > 0) model_hist = e.payload[(L-1)*8 +: 8];
        end else begin
            wb = (S == 1) ? 8 : (S == 2) ? 4 : 3;
            for (int w = 0; w * wb < L; w++) begin
                inv = $countones(e.payload[w*wb*8 +: 8] ^ model_hist) > 4;
                e.code[w] = inv;
                for (int b = w * wb; b < w * wb + wb && b < L; b++) begin
                    e.slot[b*8 +: 8] = e.payload[b*8 +: 8] ^ {8{inv}};
                    model_hist = e.slot[b*8 +: 8];
                end
            end
            for (int j = 0; j < S; j++) e.slot[(L+j)*8 +: 8] = e.code[j*8 +: 8];
        end
    endtask

    task automatic send(input logic [511:0] data, input int len_in, input int req,
                        input string tag);
        exp_t e;
        build_exp(data, len_in, req, tag, e);
        exp_q.push_back(e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_line  = data;
        in_len   = 7'(len_in);
        in_size  = 2'(req);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8 in_ready low after accept", 512'(in_ready), 512'(0));
    endtask

    function automatic logic [511:0] fill(input logic [7:0] v);
        logic [511:0] r;
        for (int b = 0; b < 64; b++) r[b*8 +: 8] = v;
        return r;
    endfunction

    function automatic logic [511:0] rnd_line();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    // monitor: takes results with varying stalls and compares them
    int stall = 0;
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst) begin
                out_ready = 1'b0;
            end else if (out_valid && !out_ready) begin
                if (stall > 0) begin
                    stall--;
                end else begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected output", 512'(1), 512'(0));
                    end else begin
                        e = exp_q.pop_front();
                        check(out_len == e.len, {e.tag, " R2 out_len"}, 512'(out_len), 512'(e.len));
                        check(out_size == e.size, {e.tag, " R2 out_size"}, 512'(out_size), 512'(e.size));
                        check(out_code == e.code, {e.tag, " R3 out_code"}, 512'(out_code), 512'(e.code));
                        check(out_line == e.slot, {e.tag, " R4 R6 out_line"}, out_line, e.slot);
                        dec_line = out_line;
                        dec_len  = out_len;
                        dec_size = out_size;
                        #1;
                        check(dec_data == e.payload, {e.tag, " R9 decoded"}, dec_data, e.payload);
                    end
                    out_ready = 1'b1;
                    n_seen++;
                end
            end else if (out_ready) begin
                out_ready = 1'b0;
                stall = n_seen % 3;
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        logic [511:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", 512'(in_ready), 512'(1));
        check(out_valid == 1'b0, "R1 out_valid after reset", 512'(out_valid), 512'(0));

        // R1 history starts at 0x00: all-zero payload never inverts
        send(fill(8'h00), 26, 1, "R1 R3 zeros");
        // R4 all ones from zero history: first word inverts
        send(fill(8'hFF), 26, 2, "R4 ones");
        // R4 tie: 4 differing bits keep the word as is
        send(fill(8'h0F), 8, 3, "R4 tie");
        send(fill(8'h1F), 9, 3, "R4 one-bit");
        // R4 alternating words
        d = '0;
        for (int b = 0; b < 64; b++) d[b*8 +: 8] = ((b / 4) % 2 == 0) ? 8'h55 : 8'hAA;
        send(d, 40, 2, "R4 alternating");
        // R2 size clamp
        send(rnd_line(), 62, 3, "R2 room two");
        send(rnd_line(), 63, 2, "R2 room one");
        send(rnd_line(), 64, 3, "R2 full slot");
        send(rnd_line(), 100, 1, "R2 len clamp");
        // R7 empty line keeps history
        send(rnd_line(), 0, 3, "R7 empty");
        send(fill(8'hF0), 5, 1, "R7 after empty");
        // R5 no code
        send(rnd_line(), 30, 0, "R5 size zero");
        // R6 code placement at small length
        send(rnd_line(), 1, 3, "R6 len one");
        send(rnd_line(), 61, 3, "R6 len 61");
        for (int n = 0; n < 150; n++)
            send(rnd_line(), $urandom_range(0, 70), $urandom_range(0, 3), "R6 R7 random");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        report();
    end

endmodule